// File: doc/BRIEF.md
# Asynchronous SRAM bus controller

This block sits between an on-chip valid/ready request port and an external asynchronous 16-bit SRAM. It serves one word per request, read or write, and turns each into a bus cycle on the memory pins. The memory is selected by two chip enables of opposite polarity. It also has an active-low write strobe, an active-low output enable and two active-low byte-lane enables. Every phase of a bus cycle lasts a whole number of clock cycles, and that number is set by a parameter. A write holds its address for `SETUP_CYC` cycles before the write strobe falls, pulses the strobe for `PULSE_CYC` cycles, then keeps address and data for `HOLD_CYC` cycles. A read opens the output enable for `READ_CYC` cycles and captures the bus on the last of them.

When no transfer is in progress, the controller deselects the memory, which puts the device into standby. It also releases its data drivers. The data bus is split into a driven value, a drive enable and a sampled value, and the pad ring builds the tri-state buffer from these. A write request that follows a read gets one extra cycle in which every driver is released.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset and whenever no transfer is in progress, the pins are in standby: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_ub_n`=`mem_lb_n`=1, `mem_dq_oe`=0, and `req_ready`=1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after that edge until the last hold cycle has ended.
- R3: A write selects the memory for `SETUP_CYC` cycles with `mem_we_n`=1, then holds `mem_we_n`=0 for `PULSE_CYC` cycles, then keeps the memory selected with `mem_we_n`=1 for `HOLD_CYC` cycles. The write data is driven in all three phases, so the strobe's rising edge closes the window while chip enables and data are still held.
- R4: `mem_addr` holds the request's address and does not change while the memory is selected.
- R5: A read selects the memory for `SETUP_CYC` cycles with `mem_oe_n`=1, then holds `mem_oe_n`=0 for `READ_CYC` cycles, then keeps the memory selected with `mem_oe_n`=1 for `HOLD_CYC` cycles. `mem_we_n` stays 1 throughout.
- R6: `rsp_done` is high for exactly one cycle, the first hold cycle of every transfer. On a read, `rsp_rdata` then carries the bus value sampled at the end of the last output-enable cycle. Bits [15:8] are forced to 0 unless `req_be[1]` was set, and bits [7:0] are forced to 0 unless `req_be[0]` was set. `rsp_rdata` keeps that value until the next read completes.
- R7: While the memory is selected, `mem_ub_n` = !`req_be[1]` and `mem_lb_n` = !`req_be[0]` of the request being served.
- R8: `mem_dq_oe` is high only during the selected cycles of a write, and never while `mem_oe_n` is low.
- R9: Between two transfers the memory is deselected for at least one cycle, so the address only changes while the chip enables are inactive.
- R10: When a write is taken and the previous transfer was a read, one cycle with every pin in the standby state and `req_ready`=0 comes before the write's setup phase.
- R11: `mem_we_n` and `mem_oe_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables: bit 1 upper byte, bit 0 lower byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, lanes not enabled read as zero |
| mem_addr | output | AW | SRAM address |
| mem_dq_out | output | 16 | Data to drive onto the SRAM bus |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | 16 | Data sampled from the SRAM bus |
| mem_ce1_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |

## Verification
On a write, the completion pulse and the closing of the write window happen in the same cycle: `rsp_done` rises at the same edge where `mem_we_n` returns high, while chip enables and data are still held. For reads, the turnaround decision and a new request being taken also meet at one edge. The bench provokes both by keeping `req_valid` high across mixed write/read sequences. These include read-then-write, write-then-write to the same word with different lane masks, and reads with partial lane masks. A reference model is built from queues of expected pin states and compares every pin and response on every clock. A separate behavioural memory on the pins checks that the bytes actually written come back on later reads.

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
  parameter int AW        = 18,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int READ_CYC  = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          rsp_done,
  output logic [15:0]   rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n
);
  localparam int CW = $clog2(SETUP_CYC + PULSE_CYC + READ_CYC + HOLD_CYC + 1) + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_TURN, ST_SETUP, ST_ACTIVE, ST_HOLD} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic          op_wr, last_rd, done_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q, rdata_q;
  logic [1:0]    be_q;
  logic          sel, take;

  assign take = req_valid && (state == ST_IDLE);
  assign sel  = (state == ST_SETUP) || (state == ST_ACTIVE) || (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      op_wr   <= 1'b0;
      last_rd <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      be_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: if (take) begin
          op_wr   <= req_write;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          last_rd <= !req_write;
          cnt     <= CW'(SETUP_CYC - 1);
          state   <= (req_write && last_rd) ? ST_TURN : ST_SETUP;
        end
        ST_TURN: state <= ST_SETUP;
        ST_SETUP: if (cnt == '0) begin
          state <= ST_ACTIVE;
          cnt   <= op_wr ? CW'(PULSE_CYC - 1) : CW'(READ_CYC - 1);
        end else cnt <= cnt - 1'b1;
        ST_ACTIVE: if (cnt == '0) begin
          state  <= ST_HOLD;
          cnt    <= CW'(HOLD_CYC - 1);
          done_q <= 1'b1;
          if (!op_wr) rdata_q <= mem_dq_in & {{8{be_q[1]}}, {8{be_q[0]}}};
        end else cnt <= cnt - 1'b1;
        ST_HOLD: if (cnt == '0) state <= ST_IDLE;
                 else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_dq_oe  = sel && op_wr;
  assign mem_ce1_n  = !sel;
  assign mem_ce2    = sel;
  assign mem_we_n   = !((state == ST_ACTIVE) && op_wr);
  assign mem_oe_n   = !((state == ST_ACTIVE) && !op_wr);
  assign mem_ub_n   = !(sel && be_q[1]);
  assign mem_lb_n   = !(sel && be_q[0]);

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);
  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));
  assert_strobe_inside_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe));
  assert_close_by_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe && $stable(mem_dq_out)));
  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  assert_take_in_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (mem_ce1_n && !mem_ce2));
endmodule

// File: tb/sram_bus_ctrl_tb.sv
module sram_bus_ctrl_tb;
  localparam int AW = 6, S = 2, P = 3, RD = 2, H = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_done, mem_dq_oe, ce1_n, ce2, we_n, oe_n, ub_n, lb_n;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  sram_bus_ctrl #(.AW(AW), .SETUP_CYC(S), .PULSE_CYC(P), .READ_CYC(RD), .HOLD_CYC(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_ce1_n(ce1_n), .mem_ce2(ce2), .mem_we_n(we_n), .mem_oe_n(oe_n),
    .mem_ub_n(ub_n), .mem_lb_n(lb_n));

  // pin-level memory model
  logic [15:0] sram [64];
  logic sel_pins;
  assign sel_pins = !ce1_n && ce2;
  assign mem_dq_in = (sel_pins && !oe_n && we_n) ?
    {(!ub_n ? sram[mem_addr][15:8] : 8'hA5), (!lb_n ? sram[mem_addr][7:0] : 8'h5A)} : 16'hFFFF;
  always @(posedge we_n) if (rst_n && sel_pins) begin
    if (!ub_n) sram[mem_addr][15:8] = mem_dq_out[15:8];
    if (!lb_n) sram[mem_addr][7:0]  = mem_dq_out[7:0];
  end

  // reference model
  typedef struct {
    logic ce1_n, ce2, we_n, oe_n, ub_n, lb_n, dq_oe, ready, done;
    logic [15:0] dout, rdata;
    logic [AW-1:0] addr;
    int kind;
  } exp_t;
  exp_t q[$];
  logic [15:0] refmem [64];
  bit last_rd = 1'b0;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  function automatic exp_t idle_e(logic rdy, int k);
    exp_t e;
    e.ce1_n = 1; e.ce2 = 0; e.we_n = 1; e.oe_n = 1; e.ub_n = 1; e.lb_n = 1;
    e.dq_oe = 0; e.ready = rdy; e.done = 0; e.dout = '0; e.rdata = '0; e.addr = '0; e.kind = k;
    return e;
  endfunction

  task automatic push_txn(bit wr, logic [AW-1:0] a, logic [15:0] d, logic [1:0] be);
    exp_t e;
    if (wr && last_rd) q.push_back(idle_e(1'b0, 1));
    e.ce1_n = 0; e.ce2 = 1; e.we_n = 1; e.oe_n = 1; e.ub_n = !be[1]; e.lb_n = !be[0];
    e.dq_oe = wr; e.ready = 0; e.done = 0; e.dout = d; e.addr = a; e.kind = wr ? 2 : 3;
    e.rdata = refmem[a] & {{8{be[1]}}, {8{be[0]}}};
    for (int i = 0; i < S; i++) q.push_back(e);
    e.we_n = !wr; e.oe_n = wr;
    for (int i = 0; i < (wr ? P : RD); i++) q.push_back(e);
    e.we_n = 1; e.oe_n = 1;
    for (int i = 0; i < H; i++) begin e.done = (i == 0); q.push_back(e); end
    if (wr) begin
      if (be[1]) refmem[a][15:8] = d[15:8];
      if (be[0]) refmem[a][7:0] = d[7:0];
    end
    last_rd = !wr;
  endtask

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string tag(int k);
    return (k == 0) ? "R1" : (k == 1) ? "R10" : (k == 2) ? "R3" : "R5";
  endfunction

  logic [15:0] last_rdata = '0;
  always @(negedge clk) if (rst_n && !finished) begin
    exp_t e;
    e = (q.size() > 0) ? q.pop_front() : idle_e(1'b1, 0);
    chk({ce1_n, ce2, we_n, oe_n} == {e.ce1_n, e.ce2, e.we_n, e.oe_n}, tag(e.kind), "ctrl",
        {ce1_n, ce2, we_n, oe_n}, {e.ce1_n, e.ce2, e.we_n, e.oe_n});
    chk({ub_n, lb_n} == {e.ub_n, e.lb_n}, "R7", "lanes", {ub_n, lb_n}, {e.ub_n, e.lb_n});
    chk(mem_dq_oe == e.dq_oe, "R8", "dq_oe", mem_dq_oe, e.dq_oe);
    chk(!(mem_dq_oe && !oe_n), "R8", "contention", {mem_dq_oe, oe_n}, 2'b11);
    chk(!(!we_n && !oe_n), "R11", "strobes", {we_n, oe_n}, 2'b11);
    chk(req_ready == e.ready, "R2", "ready", req_ready, e.ready);
    chk(rsp_done == e.done, "R6", "done", rsp_done, e.done);
    if (e.kind >= 2) chk(mem_addr == e.addr, "R4", "addr", mem_addr, e.addr);
    if (e.dq_oe) chk(mem_dq_out == e.dout, "R3", "wdata", mem_dq_out, e.dout);
    if (e.done && e.kind == 3) last_rdata = e.rdata;
    chk(rsp_rdata == last_rdata, "R6", "rdata", rsp_rdata, last_rdata);
    if (req_valid && req_ready) push_txn(req_write, req_addr, req_wdata, req_be);
  end

  task automatic do_req(bit wr, logic [AW-1:0] a, logic [15:0] d, logic [1:0] be);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin sram[i] = 16'h0; refmem[i] = 16'h0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);  // R1 reset state compared by the model
    @(posedge clk); #1;
    do_req(1, 6'd3, 16'h1234, 2'b11);          // R3 write
    do_req(1, 6'd5, 16'hABCD, 2'b01);          // R9 back-to-back writes, R7 lower lane
    do_req(1, 6'd5, 16'h55EE, 2'b10);          // R7 upper lane
    do_req(0, 6'd3, 16'h0, 2'b11);             // R5 read
    do_req(0, 6'd5, 16'h0, 2'b11);             // merged lanes
    do_req(0, 6'd5, 16'h0, 2'b01);             // R6 masked upper
    do_req(1, 6'd7, 16'h0F0F, 2'b11);          // R10 read then write
    do_req(0, 6'd7, 16'h0, 2'b10);             // R6 masked lower
    do_req(0, 6'd3, 16'h0, 2'b00);             // no lanes -> zero
    do_req(1, 6'd9, 16'hBEEF, 2'b11);          // R10 again
    repeat (4) @(posedge clk); #1;             // R1 idle standby
    do_req(0, 6'd9, 16'h0, 2'b11);
    do_req(0, 6'd1, 16'h0, 2'b11);
    repeat (S + RD + H + 6) @(posedge clk);
    @(negedge clk);
    chk(sram[3] == 16'h1234 && sram[5] == 16'h55CD && sram[9] == 16'hBEEF, "R7", "pin memory",
        {sram[3], sram[5]}, {16'h1234, 16'h55CD});
    chk(q.size() == 0, "R2", "drain", q.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog R2 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule